// File: doc/BRIEF.md
# Memory Bank Address Decoder

This block takes a system byte address and works out which of several memory banks it falls into. Each bank has a 32-bit configuration word. The word carries an enable flag, a three-bit size code and an 8 MiB-aligned base address. A bank takes part in the decode only while its own enable flag is set and the controller-wide enable input is high. When the address hits a bank, the block reports the bank index and the byte offset of the address inside that bank.

The block also has a separate combinational helper. It builds a configuration word from a base address and a byte size. For a size the banks cannot represent, it returns an all-zero word. The main result can be taken from the decode logic directly, or one clock later, depending on a parameter.

Top module: `mem_bank_decoder`

## Requirements
- R1: A bank whose word has bit 0 clear never produces a hit.
- R2: While `glob_en` is low, `hit` is 0 for every address and configuration.
- R3: The size code sits in word bits 19:17. A bank covers the bytes from its base up to, but not including, base + (4 MiB << code). Codes 0 to 6 give 4, 8, 16, 32, 64, 128 and 256 MiB. A range that runs past the top of the 32-bit space is clipped there, with no wrap to address 0.
- R4: A bank with size code 7 never produces a hit.
- R5: The bank base is the word ANDed with 0xFF800000.
- R6: Word bits outside the keep mask 0xFFDEE001 are discarded before decoding. Setting those bits changes neither `hit`, `bank_idx` nor `offset`.
- R7: When several banks contain the address, the lowest-numbered bank is reported.
- R8: On a hit, `offset` equals the address minus the selected bank's base. On a miss, `hit`, `bank_idx` and `offset` are all zero.
- R9: With `REGISTER_OUT`=1 (the default), the decode outputs show the inputs sampled at the previous rising clock edge. While `rst_n` is low, these outputs are zero.
- R10: `enc_word` is combinational. For `enc_size` of 4, 8, 16, 32, 64, 128 or 256 MiB, it equals (`enc_base` AND 0xFF800000) OR (code << 17) OR 1, where code is log2(size / 4 MiB). For any other size it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | Controller-wide decode enable |
| bank_cfg | input | NUM_BANKS*32 | Configuration words, bank i in bits [32*i+31:32*i] |
| addr | input | 32 | System byte address to decode |
| hit | output | 1 | Address falls in an active bank |
| bank_idx | output | IDX_W | Index of the selected bank |
| offset | output | 32 | Byte offset inside the selected bank |
| enc_base | input | 32 | Base address for the word builder |
| enc_size | input | 32 | Bank size in bytes for the word builder |
| enc_word | output | 32 | Built configuration word, or 0 if the size is unsupported |

## Verification
The hardest case to reach is a bank placed at 0xFF800000 with the 256 MiB code. Its nominal end lies beyond the 32-bit space, so a naive base + size compare would wrap, and the result would depend on the carry. The stimulus programs exactly that bank and probes both the last address 0xFFFFFFFF and the byte just below the base. Overlapping banks with different sizes are also set up, so that one address is claimed by two banks and a second address by only the larger one. This separates the priority rule from the range check.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
    localparam int          WORD_W    = 32;
    localparam logic [31:0] KEEP_MASK = 32'hFFDE_E001;
    localparam logic [31:0] BASE_MASK = 32'hFF80_0000;
    localparam int          CODE_LSB  = 17;
    localparam int          CODE_W    = 3;
    localparam int          UNIT_LOG2 = 22;             // 4 MiB unit
    localparam logic [2:0]  CODE_BAD  = 3'd7;
    localparam int          CODE_MAX  = 6;

    typedef struct packed {
        logic              on;
        logic [CODE_W-1:0] code;
        logic [WORD_W-1:0] base;
    } bank_fields_t;

    function automatic bank_fields_t split_word(input logic [WORD_W-1:0] raw);
        bank_fields_t f;
        logic [WORD_W-1:0] kept;
        kept   = raw & KEEP_MASK;
        f.on   = kept[0];
        f.code = kept[CODE_LSB +: CODE_W];
        f.base = kept & BASE_MASK;
        return f;
    endfunction
endpackage

// File: rtl/mbd_bank_match.sv
module mbd_bank_match
    import mbd_pkg::*;
(
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              glob_en,
    input  logic [WORD_W-1:0] addr,
    output logic              match,
    output logic [WORD_W-1:0] delta
);
    bank_fields_t      f;
    logic [WORD_W:0]   span;      // one extra bit so 256 MiB never overflows
    logic              usable;
    logic              above;

    always_comb begin
        f      = split_word(cfg_word);
        span   = (WORD_W+1)'(1) << (UNIT_LOG2 + int'(f.code));
        usable = f.on && glob_en && (f.code != CODE_BAD);
        above  = (addr >= f.base);
        delta  = addr - f.base;
        match  = usable && above && ({1'b0, delta} < span);
    end
endmodule

// File: rtl/mbd_first_hit.sv
module mbd_first_hit #(
    parameter int NUM_BANKS = 4,
    parameter int IDX_W     = 2,
    parameter int WORD_W    = 32
) (
    input  logic [NUM_BANKS-1:0]        match_vec,
    input  logic [NUM_BANKS*WORD_W-1:0] delta_vec,
    output logic                        any_hit,
    output logic [IDX_W-1:0]            first_idx,
    output logic [WORD_W-1:0]           first_delta
);
    always_comb begin
        any_hit     = 1'b0;
        first_idx   = '0;
        first_delta = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                any_hit     = 1'b1;
                first_idx   = IDX_W'(i);
                first_delta = delta_vec[i*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/mbd_word_build.sv
module mbd_word_build
    import mbd_pkg::*;
(
    input  logic [WORD_W-1:0] base_in,
    input  logic [WORD_W-1:0] size_in,
    output logic [WORD_W-1:0] word_out
);
    logic              found;
    logic [CODE_W-1:0] code;

    always_comb begin
        found = 1'b0;
        code  = '0;
        for (int c = 0; c <= CODE_MAX; c++) begin
            if (size_in == (WORD_W'(1) << (UNIT_LOG2 + c))) begin
                found = 1'b1;
                code  = CODE_W'(c);
            end
        end
        word_out = '0;
        if (found) begin
            word_out                       = base_in & BASE_MASK;
            word_out[CODE_LSB +: CODE_W]   = code;
            word_out[0]                    = 1'b1;
        end
    end
endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
    import mbd_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter bit REGISTER_OUT = 1'b1,
    localparam int IDX_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        glob_en,
    input  logic [NUM_BANKS*WORD_W-1:0] bank_cfg,
    input  logic [WORD_W-1:0]           addr,
    output logic                        hit,
    output logic [IDX_W-1:0]            bank_idx,
    output logic [WORD_W-1:0]           offset,
    input  logic [WORD_W-1:0]           enc_base,
    input  logic [WORD_W-1:0]           enc_size,
    output logic [WORD_W-1:0]           enc_word
);
    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] off;
    } dec_out_t;

    logic [NUM_BANKS-1:0]        match_vec;
    logic [NUM_BANKS*WORD_W-1:0] delta_vec;
    logic                        any_hit;
    logic [IDX_W-1:0]            first_idx;
    logic [WORD_W-1:0]           first_delta;
    dec_out_t                    out_d, out_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        mbd_bank_match u_match (
            .cfg_word (bank_cfg[b*WORD_W +: WORD_W]),
            .glob_en  (glob_en),
            .addr     (addr),
            .match    (match_vec[b]),
            .delta    (delta_vec[b*WORD_W +: WORD_W])
        );
    end

    mbd_first_hit #(
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (IDX_W),
        .WORD_W    (WORD_W)
    ) u_first (
        .match_vec   (match_vec),
        .delta_vec   (delta_vec),
        .any_hit     (any_hit),
        .first_idx   (first_idx),
        .first_delta (first_delta)
    );

    mbd_word_build u_build (
        .base_in  (enc_base),
        .size_in  (enc_size),
        .word_out (enc_word)
    );

    always_comb begin
        out_d     = '0;
        out_d.hit = any_hit;
        if (any_hit) begin
            out_d.idx = first_idx;
            out_d.off = first_delta;
        end
    end

    if (REGISTER_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign hit      = out_q.hit;
    assign bank_idx = out_q.idx;
    assign offset   = out_q.off;

    // ---------------- assertions ----------------
    logic [WORD_W-1:0] sel_word;
    assign sel_word = bank_cfg[first_idx*WORD_W +: WORD_W];

    assert_bank_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> sel_word[0]);

    assert_global_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> !any_hit);

    assert_bad_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (sel_word[CODE_LSB +: CODE_W] != CODE_BAD));

    assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ((match_vec & ((NUM_BANKS'(1) << first_idx) - NUM_BANKS'(1))) == '0));

    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_d.hit |-> (out_d.off == '0 && out_d.idx == '0));

    assert_word_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_word != '0) |-> (enc_word[0] && enc_word[CODE_LSB +: CODE_W] != CODE_BAD));
endmodule

// File: tb/tb_mem_bank_decoder.sv
module tb_mem_bank_decoder;
    localparam int NB = 4;
    localparam logic [31:0] MIB = 32'h0010_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            glob_en = 1'b0;
    logic [NB*32-1:0] bank_cfg = '0;
    logic [31:0]     addr = '0;
    logic            hit;
    logic [1:0]      bank_idx;
    logic [31:0]     offset;
    logic [31:0]     enc_base = '0;
    logic [31:0]     enc_size = '0;
    logic [31:0]     enc_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mem_bank_decoder #(.NUM_BANKS(NB), .REGISTER_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .bank_cfg(bank_cfg),
        .addr(addr), .hit(hit), .bank_idx(bank_idx), .offset(offset),
        .enc_base(enc_base), .enc_size(enc_size), .enc_word(enc_word)
    );

    function automatic logic [31:0] mk(input logic [31:0] base, input int code, input bit en);
        return (base & 32'hFF80_0000) | (32'(code) << 17) | 32'(en);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_bank(input int b, input logic [31:0] w);
        bank_cfg[b*32 +: 32] = w;
    endtask

    task automatic probe(input string req, input logic [31:0] a, input bit eh,
                         input int eb, input logic [31:0] eo);
        @(negedge clk);
        addr = a;
        @(posedge clk);
        #1;
        chk(req, "hit", 32'(hit), 32'(eh));
        chk(req, "bank", 32'(bank_idx), 32'(eb));
        chk(req, "offset", offset, eo);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        glob_en = 1'b1;
        bank_cfg = '0;
        set_bank(0, mk(32'h0, 0, 1));
        addr = 32'h10;
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "reset hit", 32'(hit), 32'd0);
        chk("R9", "reset offset", offset, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R9", "first registered hit", 32'(hit), 32'd1);
        chk("R9", "first registered offset", offset, 32'h10);
    endtask

    task automatic t_basic();
        @(negedge clk);
        bank_cfg = '0;
        glob_en  = 1'b1;
        set_bank(0, mk(32'h0000_0000, 1, 1));       // 8 MiB
        set_bank(1, mk(32'h0080_0000, 2, 1));       // 16 MiB
        probe("R3", 32'h0010_0000, 1, 0, 32'h0010_0000);
        probe("R3", 32'h007F_FFFF, 1, 0, 32'h007F_FFFF);
        probe("R5", 32'h0080_0000, 1, 1, 32'h0);
        probe("R3", 32'h017F_FFFF, 1, 1, 32'h00FF_FFFF);
        probe("R8", 32'h0180_0000, 0, 0, 32'h0);
    endtask

    task automatic t_enables();
        @(negedge clk);
        glob_en = 1'b0;
        probe("R2", 32'h0010_0000, 0, 0, 32'h0);
        @(negedge clk);
        glob_en = 1'b1;
        set_bank(1, mk(32'h0080_0000, 2, 0));
        probe("R1", 32'h0090_0000, 0, 0, 32'h0);
        probe("R1", 32'h0000_0040, 1, 0, 32'h40);
    endtask

    task automatic t_bad_code();
        @(negedge clk);
        set_bank(2, mk(32'h1000_0000, 7, 1));
        probe("R4", 32'h1000_0000, 0, 0, 32'h0);
        probe("R4", 32'h1000_1234, 0, 0, 32'h0);
    endtask

    task automatic t_overlap();
        @(negedge clk);
        bank_cfg = '0;
        set_bank(1, mk(32'h2000_0000, 0, 1));       // 4 MiB
        set_bank(3, mk(32'h2000_0000, 2, 1));       // 16 MiB
        probe("R7", 32'h2010_0000, 1, 1, 32'h0010_0000);
        probe("R7", 32'h2050_0000, 1, 3, 32'h0050_0000);
    endtask

    task automatic t_top_edge();
        @(negedge clk);
        bank_cfg = '0;
        set_bank(2, mk(32'hFF80_0000, 6, 1));       // 256 MiB past 2^32
        probe("R3", 32'hFFFF_FFFF, 1, 2, 32'h007F_FFFF);
        probe("R3", 32'hFF7F_FFFF, 0, 0, 32'h0);
        probe("R3", 32'h0000_0000, 0, 0, 32'h0);
    endtask

    task automatic t_mask();
        @(negedge clk);
        bank_cfg = '0;
        set_bank(0, mk(32'h0, 1, 1) | 32'h0021_1FFE);
        probe("R6", 32'h0070_0000, 1, 0, 32'h0070_0000);
        probe("R6", 32'h0080_0000, 0, 0, 32'h0);
    endtask

    task automatic t_encode();
        enc_base = 32'h1234_5678;
        enc_size = 64 * MIB;
        #1;
        chk("R10", "64MiB", enc_word, 32'h1208_0001);
        enc_size = 4 * MIB;
        #1;
        chk("R10", "4MiB", enc_word, 32'h1200_0001);
        enc_size = 256 * MIB;
        #1;
        chk("R10", "256MiB", enc_word, 32'h120C_0001);
        enc_size = 12 * MIB;
        #1;
        chk("R10", "12MiB", enc_word, 32'h0);
        enc_size = 512 * MIB;
        #1;
        chk("R10", "512MiB", enc_word, 32'h0);
        enc_size = 2 * MIB;
        #1;
        chk("R10", "2MiB", enc_word, 32'h0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_enables();
        t_bad_code();
        t_overlap();
        t_top_edge();
        t_mask();
        t_encode();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule